// File: doc/BRIEF.md
# Multi-Mode Inversion Link Encoder and Decoder

This block cuts the energy spent on a wide on-chip link. For every body flit it looks at four ways to put the payload on the wires: unchanged, with its odd-position bits flipped, with its even-position bits flipped, or with every bit flipped. It places each variant next to the word that was last driven on the link and estimates the switching cost. Rising edges on single wires and toggles between neighbouring wires both add to that cost. The cheapest variant is registered onto the link, and a 2-bit action code travels with it.

The link word is `LINK_W` bits wide. Bits `[LINK_W-1:LINK_W-2]` carry the action code and bits `[LINK_W-3:0]` carry the payload. Because the code is part of the driven word, the next cost estimate also counts toggles on the code wires. The receive side is a purely combinational decoder. It reads the code from the received word and undoes the flips, so the original payload is recovered exactly.

Top module: `mmi_link_codec`

## Requirements
- R1: While `rst` is high, `link_valid` is 0 and `link_word` is all zeros on the following clock edge.
- R2: `link_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: The action codes are 00 none, 10 odd, 01 even and 11 full. The code is placed in `link_word[LINK_W-1:LINK_W-2]`. Payload bit i equals `in_data[i]` XOR (code[1] if i is odd, code[0] if i is even).
- R4: The chosen link word has the smallest cost among the four candidates. The cost is measured against the previously driven `link_word` over all `LINK_W` wires. It equals the number of 0-to-1 wire changes, plus 4 for each adjacent pair where exactly one wire toggles, plus 8 for each adjacent pair where both wires toggle to different new values.
- R5: When several candidates share the lowest cost, the first in the order none, odd, even, full is taken.
- R6: When `in_valid` is low, `link_word` keeps its value. The next cost comparison is made against the last word actually transferred.
- R7: `rx_data` equals the payload field of `rx_word` with the flips of R3 undone, using the code held in `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A payload flit is transferred this cycle |
| in_data | input | LINK_W-2 | Payload flit to encode |
| link_valid | output | 1 | Registered link word is new this cycle |
| link_word | output | LINK_W | Encoded word: action code on top, payload below |
| rx_word | input | LINK_W | Word received from the link |
| rx_data | output | LINK_W-2 | Decoded payload |

## Verification
The bench builds the block with `LINK_W = 12`, which gives a 10-bit payload. At this width ties between candidates happen often, so the tie order of R5 is exercised many times instead of rarely. Random flits separated by random idle gaps exercise the hold behaviour of R6. Counting and walking-one traffic covers the correlated patterns where odd or even inversion wins. The link output is looped back into the decoder, so every transfer also checks that the payload survives the round trip.

// File: rtl/mmi_pkg.sv
package mmi_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_EVEN = 2'b01,
        ACT_ODD  = 2'b10,
        ACT_FULL = 2'b11
    } act_e;

    localparam int NUM_CAND = 4;

endpackage

// File: rtl/inv_bit_flipper.sv
// Applies (or undoes) an inversion action: odd positions follow code[1],
// even positions follow code[0]. XOR makes the same block its own inverse.
module inv_bit_flipper #(
    parameter int PAY_W = 14
) (
    input  logic [1:0]       code,
    input  logic [PAY_W-1:0] din,
    output logic [PAY_W-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < PAY_W; i++) begin : g_bit
            if (i % 2 == 1) begin : g_odd
                assign dout[i] = din[i] ^ code[1];
            end else begin : g_even
                assign dout[i] = din[i] ^ code[0];
            end
        end
    endgenerate
endmodule

// File: rtl/inv_ones_count.sv
module inv_ones_count #(
    parameter int IN_W  = 16,
    parameter int CNT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  vec,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < IN_W; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/inv_cand_cost.sv
// Per-wire rise detectors and per-pair coupling classifiers for one
// candidate word, followed by ones counters and the weighted sum.
module inv_cand_cost #(
    parameter int W      = 16,
    parameter int COST_W = $clog2(9 * W + 1)
) (
    input  logic [W-1:0]      prev_word,
    input  logic [W-1:0]      cand_word,
    output logic [COST_W-1:0] cost
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0] toggle;
    logic [W-1:0] rise;
    logic [W-2:0] one_side;
    logic [W-2:0] opposed;
    logic [CW-1:0] rise_n;
    logic [CW-1:0] one_n;
    logic [CW-1:0] opp_n;

    assign toggle = prev_word ^ cand_word;
    assign rise   = ~prev_word & cand_word;

    genvar p;
    generate
        for (p = 0; p < W - 1; p++) begin : g_pair
            assign one_side[p] = toggle[p] ^ toggle[p+1];
            assign opposed[p]  = toggle[p] & toggle[p+1] & (cand_word[p] ^ cand_word[p+1]);
        end
    endgenerate

    inv_ones_count #(.IN_W(W),     .CNT_W(CW)) u_cnt_rise (.vec(rise),     .cnt(rise_n));
    inv_ones_count #(.IN_W(W - 1), .CNT_W(CW)) u_cnt_one  (.vec(one_side), .cnt(one_n));
    inv_ones_count #(.IN_W(W - 1), .CNT_W(CW)) u_cnt_opp  (.vec(opposed),  .cnt(opp_n));

    assign cost = COST_W'(rise_n) + (COST_W'(one_n) << 2) + (COST_W'(opp_n) << 3);
endmodule

// File: rtl/inv_action_select.sv
// Picks the lowest cost; strict comparisons in the order none, odd, even,
// full keep the earliest candidate on a tie.
module inv_action_select #(
    parameter int COST_W = 8
) (
    input  logic [COST_W-1:0] cost_none,
    input  logic [COST_W-1:0] cost_odd,
    input  logic [COST_W-1:0] cost_even,
    input  logic [COST_W-1:0] cost_full,
    output mmi_pkg::act_e     act
);
    import mmi_pkg::*;

    logic [COST_W-1:0] best;

    always_comb begin
        act  = ACT_NONE;
        best = cost_none;
        if (cost_odd < best) begin
            act  = ACT_ODD;
            best = cost_odd;
        end
        if (cost_even < best) begin
            act  = ACT_EVEN;
            best = cost_even;
        end
        if (cost_full < best) begin
            act  = ACT_FULL;
        end
    end
endmodule

// File: rtl/mmi_link_codec.sv
module mmi_link_codec #(
    parameter int LINK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LINK_W-3:0] in_data,
    output logic              link_valid,
    output logic [LINK_W-1:0] link_word,
    input  logic [LINK_W-1:0] rx_word,
    output logic [LINK_W-3:0] rx_data
);
    import mmi_pkg::*;

    localparam int PAY_W  = LINK_W - 2;
    localparam int COST_W = $clog2(9 * LINK_W + 1);

    typedef struct packed {
        logic              vld;
        logic [LINK_W-1:0] word;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CAND-1:0][LINK_W-1:0] cand_word;
    logic [NUM_CAND-1:0][COST_W-1:0] cand_cost;
    act_e                            act;

    // Candidate k carries action code k; the flipper builds its payload.
    genvar k;
    generate
        for (k = 0; k < NUM_CAND; k++) begin : g_cand
            logic [PAY_W-1:0] pay;
            inv_bit_flipper #(.PAY_W(PAY_W)) u_flip (
                .code (2'(k)),
                .din  (in_data),
                .dout (pay)
            );
            assign cand_word[k] = {2'(k), pay};
            inv_cand_cost #(.W(LINK_W), .COST_W(COST_W)) u_cost (
                .prev_word (st_q.word),
                .cand_word (cand_word[k]),
                .cost      (cand_cost[k])
            );
        end
    endgenerate

    inv_action_select #(.COST_W(COST_W)) u_sel (
        .cost_none (cand_cost[ACT_NONE]),
        .cost_odd  (cand_cost[ACT_ODD]),
        .cost_even (cand_cost[ACT_EVEN]),
        .cost_full (cand_cost[ACT_FULL]),
        .act       (act)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word = cand_word[act];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_valid = st_q.vld;
    assign link_word  = st_q.word;

    inv_bit_flipper #(.PAY_W(PAY_W)) u_dec (
        .code (rx_word[LINK_W-1:LINK_W-2]),
        .din  (rx_word[PAY_W-1:0]),
        .dout (rx_data)
    );
endmodule

// File: rtl/mmi_link_codec_chk.sv
module mmi_link_codec_chk #(
    parameter int LINK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [LINK_W-3:0] in_data,
    input logic              link_valid,
    input logic [LINK_W-1:0] link_word,
    input logic [LINK_W-1:0] rx_word,
    input logic [LINK_W-3:0] rx_data
);
    localparam int PAY_W = LINK_W - 2;

    logic [PAY_W-1:0] tx_mask;
    logic [PAY_W-1:0] rx_mask;

    always_comb begin
        for (int i = 0; i < PAY_W; i++) begin
            tx_mask[i] = (i % 2 == 1) ? link_word[LINK_W-1] : link_word[LINK_W-2];
            rx_mask[i] = (i % 2 == 1) ? rx_word[LINK_W-1]   : rx_word[LINK_W-2];
        end
    end

    p_valid_set_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> link_valid);

    p_valid_clr_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !link_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(link_word));

    p_payload_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((link_word[PAY_W-1:0] ^ tx_mask) == $past(in_data)));

    p_decode_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_data ^ rx_mask) == rx_word[PAY_W-1:0]);
endmodule

bind mmi_link_codec mmi_link_codec_chk #(.LINK_W(LINK_W)) u_chk (.*);

// File: tb/mmi_link_codec_tb.sv
module mmi_link_codec_tb;
    localparam int LW = 12;
    localparam int PW = LW - 2;

    typedef struct {
        logic [LW-1:0] word;
        logic [PW-1:0] data;
        bit            tie;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_data = '0;
    logic          link_valid;
    logic [LW-1:0] link_word;
    logic [LW-1:0] rx_word;
    logic [PW-1:0] rx_data;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    logic [LW-1:0] prev_m = '0;
    logic [LW-1:0] last_word = '0;
    logic          sampled_v = 1'b0;

    always #5 clk = ~clk;

    assign rx_word = link_word;

    mmi_link_codec #(.LINK_W(LW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .link_valid(link_valid), .link_word(link_word),
        .rx_word(rx_word), .rx_data(rx_data)
    );

    function automatic logic [PW-1:0] flip(logic [PW-1:0] d, logic [1:0] c);
        logic [PW-1:0] r;
        for (int i = 0; i < PW; i++) r[i] = d[i] ^ ((i % 2 == 1) ? c[1] : c[0]);
        return r;
    endfunction

    function automatic int cost_of(logic [LW-1:0] p, logic [LW-1:0] c);
        int s = 0;
        for (int i = 0; i < LW; i++) if (!p[i] && c[i]) s++;
        for (int i = 0; i < LW - 1; i++) begin
            logic a, b;
            a = p[i] ^ c[i];
            b = p[i+1] ^ c[i+1];
            if (a ^ b) s += 4;
            else if (a && b && (c[i] != c[i+1])) s += 8;
        end
        return s;
    endfunction

    task automatic check(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: computes the expected word from the requirements and queues it.
    task automatic send(logic [PW-1:0] d);
        logic [1:0] order [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
        int best_c, n_best;
        logic [LW-1:0] best_w;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        best_c = 1 << 30;
        n_best = 0;
        best_w = '0;
        for (int k = 0; k < 4; k++) begin
            logic [LW-1:0] w;
            int c;
            w = {order[k], flip(d, order[k])};
            c = cost_of(prev_m, w);
            if (c < best_c) begin
                best_c = c; best_w = w; n_best = 1;
            end else if (c == best_c) begin
                n_best++;
            end
        end
        e.word = best_w;
        e.data = d;
        e.tie  = (n_best > 1);
        q.push_back(e);
        prev_m = best_w;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(posedge clk) sampled_v <= rst ? 1'b0 : in_valid;

    // Monitor
    always @(negedge clk) begin
        if (rst) begin
            check(link_valid == 1'b0 && link_word == '0, "R1", link_word, '0);
        end else begin
            check(link_valid == sampled_v, "R2", LW'(link_valid), LW'(sampled_v));
            if (link_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected word", link_word, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.tie) check(link_word == e.word, "R5 tie order", link_word, e.word);
                    else       check(link_word == e.word, "R4 min cost", link_word, e.word);
                    check(flip(link_word[PW-1:0], link_word[LW-1:LW-2]) == e.data,
                          "R3 payload field", LW'(flip(link_word[PW-1:0], link_word[LW-1:LW-2])), LW'(e.data));
                    check(rx_data == e.data, "R7 round trip", LW'(rx_data), LW'(e.data));
                    last_word = e.word;
                end
            end else begin
                check(link_word == last_word, "R6 hold", link_word, last_word);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        send('0);
        send('1);
        send({PW/2{2'b10}});
        send({PW/2{2'b01}});
        idle();
        idle();
        for (int n = 0; n < 400; n++) begin
            send(PW'($urandom));
            if ($urandom_range(0, 3) == 0) idle();
        end
        for (int n = 0; n < 200; n++) send(PW'(n));
        for (int n = 0; n < PW; n++) send(PW'(1) << n);
        for (int n = 0; n < 50; n++) send((n % 2 == 0) ? {PW/2{2'b10}} : {PW/2{2'b01}});
        repeat (4) idle();
        check(q.size() == 0, "R2 drained", LW'(q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule